// File: doc/BRIEF.md
# Lane Low-Power Entry Scheduler

This block belongs to the transmit side of a display serial link. Between bursts of high-speed traffic it decides how far the lanes may power down. In command mode it follows the pending-packet flag directly. In video mode it weighs each announced idle or blanking interval against the programmed transition costs and picks one of three outcomes. In the first, every lane stays in high-speed and the gap is padded with blanking. In the second, only the data lanes drop to low-power. In the third, the data lanes and the clock lane both drop to low-power.

Each interval is announced by a one-cycle start strobe together with its length in lane byte clocks. The block latches its decision and the timing values on that strobe and plays the decision out over the interval. It returns the data lanes early enough to absorb their wake-up time. In the third outcome it re-raises the clock request early enough that the clock is back in high-speed before the data lanes wake. A command that was pushed to the last line of the frame keeps the clock lane active even when no video packet needs it.

Top module: `lane_lp_sched`

## Requirements
- R1: While reset is asserted (and until the first clock edge after its release), clk_hs_req = 0, dat_lp_en = 1 and blank_fill = 0.
- R2: Automatic clock control is on only when cfg_clk_req_en = 1 and cfg_auto_clk = 1. Otherwise clk_hs_req equals cfg_clk_req_en in every cycle after reset, and no outcome lets the clock lane go low-power.
- R3: In command mode (video_mode = 0), outside an interval and with automatic control on, clk_hs_req = hs_pending OR last_line_cmd, dat_lp_en = NOT hs_pending, and blank_fill = 0, all combinationally in the same cycle.
- R4: In video mode, outside an interval, the lanes are in high-speed: dat_lp_en = 0, blank_fill = 0, and clk_hs_req = 1 under automatic control.
- R5: A start strobe is accepted only in video mode, with ivl_len > 0, and when no interval is running. An accepted interval occupies exactly ivl_len cycles, beginning in the cycle after the strobe edge. Other strobes have no effect on the outputs.
- R6: Let the data round trip D = t_dat_hs2lp + t_dat_lp2hs. If ivl_len < D, then during the interval blank_fill = 1, dat_lp_en = 0, and the clock is held (clk_hs_req = 1 under automatic control).
- R7: If ivl_len >= D and the third outcome is not taken, blank_fill = 0 and the clock is held. In the interval cycle with r cycles remaining (r = ivl_len for the first cycle, 1 for the last), dat_lp_en = 1 exactly when r > t_dat_lp2hs.
- R8: Let the clock round trip C = t_clk_hs2lp + t_clk_lp2hs + D. If ivl_len >= C under automatic control with last_line_cmd = 0 at the strobe, the data lanes behave as in R7. clk_hs_req = 0 exactly in those cycles where elapsed cycles (ivl_len − r) >= t_dat_hs2lp and r > t_dat_lp2hs + t_clk_lp2hs.
- R9: last_line_cmd = 1 at the strobe rules out the third outcome (it falls back to R7). In command mode it raises clk_hs_req as given in R3.
- R10: The transition times are captured at the strobe. Changing them while an interval runs does not alter that interval's outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_clk_req_en | input | 1 | Clock-lane high-speed request enable |
| cfg_auto_clk | input | 1 | Automatic clock-lane control enable |
| video_mode | input | 1 | 1 = video mode, 0 = command mode |
| hs_pending | input | 1 | High-speed packets are waiting (command mode) |
| last_line_cmd | input | 1 | A deferred command is sent on the last line |
| ivl_start | input | 1 | One-cycle strobe announcing an idle interval |
| ivl_len | input | LEN_W | Interval length in byte clocks |
| t_clk_lp2hs | input | TIME_W | Clock lane low-power to high-speed time |
| t_clk_hs2lp | input | TIME_W | Clock lane high-speed to low-power time |
| t_dat_lp2hs | input | TIME_W | Data lane low-power to high-speed time |
| t_dat_hs2lp | input | TIME_W | Data lane high-speed to low-power time |
| clk_hs_req | output | 1 | Clock lane high-speed request |
| dat_lp_en | output | 1 | Data lanes low-power enable |
| blank_fill | output | 1 | Fill the current interval with blanking |

## Verification
The bench builds the block with its default widths: 10-bit transition times and a 16-bit interval length. This makes the largest round-trip cost of 4092 byte clocks reachable, and the carries in both cost sums are exercised there. Interval lengths sit exactly on the outcome boundaries, one below and at each round-trip cost, both for small timing values and with every timing value at 1023. For each case the bench predicts every interval cycle from the formulas of R6 to R8 and compares the outputs cycle by cycle.

// File: rtl/lls_pkg.sv
// Shared types of the lane low-power entry scheduler.
// Assumes nothing beyond being compiled before the modules that use it.
package lls_pkg;

    // Power outcome chosen for one interval.
    typedef enum logic [1:0] {
        OC_FILL    = 2'd0,  // all lanes stay high-speed, gap padded
        OC_DATA_LP = 2'd1,  // data lanes low-power, clock held
        OC_ALL_LP  = 2'd2   // data and clock lanes low-power
    } outcome_e;

    // Sequencer state.
    typedef enum logic [1:0] {
        ST_OFF = 2'd0,  // reset state, all lanes low-power
        ST_RUN = 2'd1,  // between intervals
        ST_IVL = 2'd2   // playing out an interval
    } state_e;

endpackage

// File: rtl/lls_cost.sv
// Round-trip cost evaluator.
// Adds the data-lane and clock-lane round-trip costs and compares them with
// the announced interval length to pick an outcome. Purely combinational.
// Assumes the clock round trip nests around the data round trip, so its
// cost includes the data cost.
module lls_cost #(
    parameter int TIME_W = 10,
    parameter int LEN_W  = 16
) (
    input  logic [LEN_W-1:0]  len,
    input  logic [TIME_W-1:0] t_clk_lp2hs,
    input  logic [TIME_W-1:0] t_clk_hs2lp,
    input  logic [TIME_W-1:0] t_dat_lp2hs,
    input  logic [TIME_W-1:0] t_dat_hs2lp,
    input  logic              clk_lp_ok,
    output lls_pkg::outcome_e outcome
);
    import lls_pkg::*;

    localparam int CW = TIME_W + 2;
    localparam int SW = (LEN_W > CW) ? LEN_W : CW;

    logic [SW-1:0] dat_rt;
    logic [SW-1:0] clk_rt;
    logic [SW-1:0] len_x;

    // Sum the round-trip costs at a width that cannot overflow.
    always_comb begin
        dat_rt = SW'(t_dat_hs2lp) + SW'(t_dat_lp2hs);
        clk_rt = dat_rt + SW'(t_clk_hs2lp) + SW'(t_clk_lp2hs);
        len_x  = SW'(len);
    end

    // Pick the deepest outcome the interval can afford.
    always_comb begin
        if (clk_lp_ok && (len_x >= clk_rt))
            outcome = OC_ALL_LP;
        else if (len_x >= dat_rt)
            outcome = OC_DATA_LP;
        else
            outcome = OC_FILL;
    end

endmodule

// File: rtl/lls_timer.sv
// Interval sequencer.
// Accepts an interval start, latches the outcome and the thresholds the
// output decoder needs, and counts the remaining cycles down to one.
// Assumes start strobes arriving while an interval runs are to be dropped.
module lls_timer #(
    parameter int TIME_W = 10,
    parameter int LEN_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ivl_start,
    input  logic               video_mode,
    input  logic [LEN_W-1:0]   len,
    input  lls_pkg::outcome_e  outcome_in,
    input  logic [TIME_W-1:0]  t_clk_lp2hs,
    input  logic [TIME_W-1:0]  t_dat_lp2hs,
    input  logic [TIME_W-1:0]  t_dat_hs2lp,
    output lls_pkg::state_e    state,
    output lls_pkg::outcome_e  outcome_q,
    output logic [LEN_W-1:0]   rem,
    output logic [LEN_W-1:0]   clk_lo_from,
    output logic [TIME_W:0]    clk_hi_at,
    output logic [TIME_W-1:0]  dat_wake
);
    import lls_pkg::*;

    logic start_ok;

    // Qualify the strobe: video mode, non-empty, sequencer free.
    assign start_ok = ivl_start && video_mode && (len != '0) && (state == ST_RUN);

    // Advance the sequencer and capture per-interval values on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_OFF;
            outcome_q   <= OC_FILL;
            rem         <= '0;
            clk_lo_from <= '0;
            clk_hi_at   <= '0;
            dat_wake    <= '0;
        end else begin
            case (state)
                ST_OFF: state <= ST_RUN;
                ST_RUN: begin
                    if (start_ok) begin
                        state       <= ST_IVL;
                        outcome_q   <= outcome_in;
                        rem         <= len;
                        clk_lo_from <= len - LEN_W'(t_dat_hs2lp);
                        clk_hi_at   <= {1'b0, t_dat_lp2hs} + {1'b0, t_clk_lp2hs};
                        dat_wake    <= t_dat_lp2hs;
                    end
                end
                ST_IVL: begin
                    if (rem == LEN_W'(1))
                        state <= ST_RUN;
                    rem <= rem - LEN_W'(1);
                end
                default: state <= ST_OFF;
            endcase
        end
    end

    // R5: an accepted start opens an interval of the requested length.
    a_r5_start_loads: assert property (@(posedge clk) disable iff (!rst_n)
        start_ok |=> (state == ST_IVL) && (rem == $past(len)));

    // R5: the last counted cycle closes the interval.
    a_r5_interval_ends: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IVL) && (rem == LEN_W'(1)) |=> (state == ST_RUN));

    // R10: captured thresholds do not move while the interval runs.
    a_r10_thresholds_held: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IVL) && (rem != LEN_W'(1)) |=>
            $stable(clk_hi_at) && $stable(dat_wake) && $stable(clk_lo_from) && $stable(outcome_q));

endmodule

// File: rtl/lls_lane_drv.sv
// Lane request decoder.
// Turns the sequencer state, the latched outcome and the remaining-cycle
// count into the clock request, data low-power enable and blanking fill.
// Outside intervals it follows the mode inputs combinationally.
// Assumes clk and rst_n are used only by its assertions.
module lls_lane_drv #(
    parameter int TIME_W = 10,
    parameter int LEN_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               auto_on,
    input  logic               cfg_clk_req_en,
    input  logic               video_mode,
    input  logic               hs_pending,
    input  logic               last_line_cmd,
    input  lls_pkg::state_e    state,
    input  lls_pkg::outcome_e  outcome_q,
    input  logic [LEN_W-1:0]   rem,
    input  logic [LEN_W-1:0]   clk_lo_from,
    input  logic [TIME_W:0]    clk_hi_at,
    input  logic [TIME_W-1:0]  dat_wake,
    output logic               clk_hs_req,
    output logic               dat_lp_en,
    output logic               blank_fill
);
    import lls_pkg::*;

    localparam int SW = (LEN_W > TIME_W + 1) ? LEN_W : TIME_W + 1;

    logic clk_hold;
    logic dat_window;
    logic clk_asleep;

    // Derive the held-clock level and the low-power windows.
    always_comb begin
        clk_hold   = auto_on ? 1'b1 : cfg_clk_req_en;
        dat_window = SW'(rem) > SW'(dat_wake);
        clk_asleep = (rem <= clk_lo_from) && (SW'(rem) > SW'(clk_hi_at));
    end

    // Decode the three lane outputs from the sequencer state.
    always_comb begin
        clk_hs_req = 1'b0;
        dat_lp_en  = 1'b1;
        blank_fill = 1'b0;
        case (state)
            ST_RUN: begin
                if (video_mode) begin
                    clk_hs_req = clk_hold;
                    dat_lp_en  = 1'b0;
                end else begin
                    clk_hs_req = auto_on ? (hs_pending || last_line_cmd) : cfg_clk_req_en;
                    dat_lp_en  = !hs_pending;
                end
            end
            ST_IVL: begin
                case (outcome_q)
                    OC_ALL_LP: begin
                        clk_hs_req = !clk_asleep;
                        dat_lp_en  = dat_window;
                    end
                    OC_DATA_LP: begin
                        clk_hs_req = clk_hold;
                        dat_lp_en  = dat_window;
                    end
                    default: begin
                        clk_hs_req = clk_hold;
                        dat_lp_en  = 1'b0;
                        blank_fill = 1'b1;
                    end
                endcase
            end
            default: ;
        endcase
    end

    // R6: blanking fill keeps every lane in high-speed under automatic control.
    a_r6_fill_all_hs: assert property (@(posedge clk) disable iff (!rst_n)
        blank_fill && auto_on |-> clk_hs_req && !dat_lp_en);

    // R8: the clock lane sleeps only while the data lanes are low-power.
    a_r8_clk_inside_data: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IVL) && auto_on && !clk_hs_req |-> dat_lp_en);

    // R2: without automatic control the clock request mirrors its enable.
    a_r2_manual_clk: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_on && (state != ST_OFF) |-> (clk_hs_req == cfg_clk_req_en));

    // R3: in command mode a pending packet keeps the data lanes active.
    a_r3_cmd_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) && !video_mode && hs_pending |-> !dat_lp_en && !blank_fill);

endmodule

// File: rtl/lane_lp_sched.sv
// Lane low-power entry scheduler, top level.
// Combines the cost evaluator, the interval sequencer and the lane decoder.
// Assumes the interval length and the strobe come from a video timing source,
// and that the transition times are given in lane byte clocks.
module lane_lp_sched #(
    parameter int TIME_W = 10,
    parameter int LEN_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_clk_req_en,
    input  logic              cfg_auto_clk,
    input  logic              video_mode,
    input  logic              hs_pending,
    input  logic              last_line_cmd,
    input  logic              ivl_start,
    input  logic [LEN_W-1:0]  ivl_len,
    input  logic [TIME_W-1:0] t_clk_lp2hs,
    input  logic [TIME_W-1:0] t_clk_hs2lp,
    input  logic [TIME_W-1:0] t_dat_lp2hs,
    input  logic [TIME_W-1:0] t_dat_hs2lp,
    output logic              clk_hs_req,
    output logic              dat_lp_en,
    output logic              blank_fill
);
    import lls_pkg::*;

    logic              auto_on;
    logic              clk_lp_ok;
    outcome_e          outcome_now;
    outcome_e          outcome_q;
    state_e            state;
    logic [LEN_W-1:0]  rem;
    logic [LEN_W-1:0]  clk_lo_from;
    logic [TIME_W:0]   clk_hi_at;
    logic [TIME_W-1:0] dat_wake;

    // Automatic clock control needs both enables; a deferred command blocks clock sleep.
    assign auto_on   = cfg_clk_req_en && cfg_auto_clk;
    assign clk_lp_ok = auto_on && !last_line_cmd;

    lls_cost #(.TIME_W(TIME_W), .LEN_W(LEN_W)) u_cost (
        .len         (ivl_len),
        .t_clk_lp2hs (t_clk_lp2hs),
        .t_clk_hs2lp (t_clk_hs2lp),
        .t_dat_lp2hs (t_dat_lp2hs),
        .t_dat_hs2lp (t_dat_hs2lp),
        .clk_lp_ok   (clk_lp_ok),
        .outcome     (outcome_now)
    );

    lls_timer #(.TIME_W(TIME_W), .LEN_W(LEN_W)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .ivl_start   (ivl_start),
        .video_mode  (video_mode),
        .len         (ivl_len),
        .outcome_in  (outcome_now),
        .t_clk_lp2hs (t_clk_lp2hs),
        .t_dat_lp2hs (t_dat_lp2hs),
        .t_dat_hs2lp (t_dat_hs2lp),
        .state       (state),
        .outcome_q   (outcome_q),
        .rem         (rem),
        .clk_lo_from (clk_lo_from),
        .clk_hi_at   (clk_hi_at),
        .dat_wake    (dat_wake)
    );

    lls_lane_drv #(.TIME_W(TIME_W), .LEN_W(LEN_W)) u_drv (
        .clk            (clk),
        .rst_n          (rst_n),
        .auto_on        (auto_on),
        .cfg_clk_req_en (cfg_clk_req_en),
        .video_mode     (video_mode),
        .hs_pending     (hs_pending),
        .last_line_cmd  (last_line_cmd),
        .state          (state),
        .outcome_q      (outcome_q),
        .rem            (rem),
        .clk_lo_from    (clk_lo_from),
        .clk_hi_at      (clk_hi_at),
        .dat_wake       (dat_wake),
        .clk_hs_req     (clk_hs_req),
        .dat_lp_en      (dat_lp_en),
        .blank_fill     (blank_fill)
    );

    // R1: reset leaves every lane low-power with nothing requested.
    a_r1_reset_lp: assert property (@(posedge clk)
        !rst_n |=> !clk_hs_req && dat_lp_en && !blank_fill);

    // R9: a deferred last-line command never lets an interval sleep the clock.
    a_r9_last_line_no_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        last_line_cmd && ivl_start && video_mode && (state == ST_RUN) |=> (outcome_q != OC_ALL_LP));

endmodule

// File: tb/tb_lane_lp_sched.sv
// Scoreboard bench: the driver predicts every interval cycle into a queue,
// the monitor pops one prediction per clock and compares it with the outputs.
module tb_lane_lp_sched;
    localparam int TW = 10;
    localparam int LW = 16;

    typedef struct {
        logic  c;
        logic  d;
        logic  b;
        string req;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_clk_req_en = 1'b0;
    logic          cfg_auto_clk = 1'b0;
    logic          video_mode = 1'b0;
    logic          hs_pending = 1'b0;
    logic          last_line_cmd = 1'b0;
    logic          ivl_start = 1'b0;
    logic [LW-1:0] ivl_len = '0;
    logic [TW-1:0] t_clp = '0, t_chs = '0, t_dlp = '0, t_dhs = '0;
    logic          clk_hs_req, dat_lp_en, blank_fill;

    int   total = 0;
    int   bad   = 0;
    exp_t sb_q[$];

    lane_lp_sched #(.TIME_W(TW), .LEN_W(LW)) dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_clk_req_en(cfg_clk_req_en), .cfg_auto_clk(cfg_auto_clk),
        .video_mode(video_mode), .hs_pending(hs_pending),
        .last_line_cmd(last_line_cmd), .ivl_start(ivl_start), .ivl_len(ivl_len),
        .t_clk_lp2hs(t_clp), .t_clk_hs2lp(t_chs),
        .t_dat_lp2hs(t_dlp), .t_dat_hs2lp(t_dhs),
        .clk_hs_req(clk_hs_req), .dat_lp_en(dat_lp_en), .blank_fill(blank_fill)
    );

    always #2 clk = ~clk;

    task automatic finish_up();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Compare the three outputs against an expectation.
    task automatic compare(string req, logic c, logic d, logic b);
        total++;
        if (clk_hs_req !== c || dat_lp_en !== d || blank_fill !== b) begin
            bad++;
            $display("FAIL %s: got clk=%b dat=%b blank=%b, expected clk=%b dat=%b blank=%b",
                     req, clk_hs_req, dat_lp_en, blank_fill, c, d, b);
        end
    endtask

    // Monitor: one prediction per clock, sampled 1 ns after the edge.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            compare(e.req, e.c, e.d, e.b);
        end
    end

    task automatic set_t(int chs, int clp, int dhs, int dlp);
        t_chs = TW'(chs); t_clp = TW'(clp); t_dhs = TW'(dhs); t_dlp = TW'(dlp);
    endtask

    // Driver: predict one interval plus two idle cycles, then run it.
    // disturb changes the timing inputs mid-interval (R10); restart pulses a
    // second strobe mid-interval (R5).
    task automatic run_ivl(int len, bit disturb, bit restart);
        int dhs = int'(t_dhs), dlp = int'(t_dlp), chs = int'(t_chs), clp = int'(t_clp);
        int dat_rt = dhs + dlp;
        int clk_rt = dat_rt + chs + clp;
        bit auto_on = cfg_clk_req_en && cfg_auto_clk;
        bit hold = auto_on ? 1'b1 : cfg_clk_req_en;
        int oc;
        string tag;
        logic [TW-1:0] sv_clp = t_clp, sv_chs = t_chs, sv_dlp = t_dlp, sv_dhs = t_dhs;
        if (auto_on && !last_line_cmd && len >= clk_rt) oc = 3;
        else if (len >= dat_rt) oc = 2;
        else oc = 1;
        tag = (oc == 3) ? "R8" : (oc == 2) ? "R7" : "R6";
        if (oc == 2 && last_line_cmd && len >= clk_rt) tag = "R9";
        if (!auto_on) tag = "R2";
        if (disturb) tag = "R10";
        if (restart) tag = "R5";
        @(negedge clk);
        ivl_len = LW'(len);
        ivl_start = 1'b1;
        for (int i = 0; i < len; i++) begin
            exp_t e;
            int r = len - i;
            e.req = tag;
            e.b = (oc == 1);
            e.d = (oc != 1) && (r > dlp);
            if (oc == 3) e.c = (i < dhs) || (r <= dlp + clp);
            else         e.c = hold;
            sb_q.push_back(e);
        end
        for (int k = 0; k < 2; k++) begin
            exp_t e;
            e.req = "R4"; e.c = hold; e.d = 1'b0; e.b = 1'b0;
            sb_q.push_back(e);
        end
        @(negedge clk);
        ivl_start = 1'b0;
        if (disturb) set_t(1, 1, 1, 1);
        if (restart) begin
            @(negedge clk);
            ivl_len = LW'(2);
            ivl_start = 1'b1;
            @(negedge clk);
            ivl_start = 1'b0;
        end
        wait (sb_q.size() == 0);
        @(negedge clk);
        t_clp = sv_clp; t_chs = sv_chs; t_dlp = sv_dlp; t_dhs = sv_dhs;
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got no end, expected completion");
        finish_up();
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 compare("R1", 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        cfg_clk_req_en = 1'b1;
        cfg_auto_clk = 1'b1;
        @(negedge clk);

        // R3: command mode follows the pending flag
        hs_pending = 1'b1;
        #1 compare("R3", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        hs_pending = 1'b0;
        #1 compare("R3", 1'b0, 1'b1, 1'b0);
        // R9: deferred last-line command keeps the clock up
        @(negedge clk);
        last_line_cmd = 1'b1;
        #1 compare("R9", 1'b1, 1'b1, 1'b0);
        @(negedge clk);
        last_line_cmd = 1'b0;

        // R5: a strobe in command mode is ignored
        ivl_len = LW'(50);
        ivl_start = 1'b1;
        @(negedge clk);
        ivl_start = 1'b0;
        #1 compare("R5", 1'b0, 1'b1, 1'b0);
        repeat (3) @(negedge clk);
        #1 compare("R5", 1'b0, 1'b1, 1'b0);

        // R4: video mode between intervals
        @(negedge clk);
        video_mode = 1'b1;
        #1 compare("R4", 1'b1, 1'b0, 1'b0);

        // Boundary lengths with small costs: D = 7, C = 18
        set_t(5, 6, 3, 4);
        run_ivl(6, 0, 0);
        run_ivl(7, 0, 0);
        run_ivl(17, 0, 0);
        run_ivl(18, 0, 0);
        run_ivl(40, 0, 0);

        // R5: zero-length strobe is ignored
        @(negedge clk);
        ivl_len = '0;
        ivl_start = 1'b1;
        @(negedge clk);
        ivl_start = 1'b0;
        #1 compare("R5", 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        #1 compare("R5", 1'b1, 1'b0, 1'b0);

        // R9: deferred command blocks the third outcome
        last_line_cmd = 1'b1;
        run_ivl(40, 0, 0);
        last_line_cmd = 1'b0;

        // R2: only one enable set
        cfg_auto_clk = 1'b0;
        run_ivl(40, 0, 0);
        cfg_auto_clk = 1'b1;
        cfg_clk_req_en = 1'b0;
        run_ivl(40, 0, 0);
        #1 compare("R2", 1'b0, 1'b0, 1'b0);
        cfg_clk_req_en = 1'b1;

        // R10 and R5: disturbances during a third-outcome interval
        run_ivl(30, 1, 0);
        run_ivl(30, 0, 1);

        // Widest costs: D = 2046, C = 4092
        set_t(1023, 1023, 1023, 1023);
        run_ivl(2045, 0, 0);
        run_ivl(2046, 0, 0);
        run_ivl(4091, 0, 0);
        run_ivl(4092, 0, 0);

        repeat (2) @(negedge clk);
        finish_up();
    end
endmodule